// File: doc/BRIEF.md
# Memory-Mapped Cycle Timer with Interrupt

This peripheral sits on a processor's data bus next to data memory. It counts clock cycles from reset, lets software read that count with a load, and lets software choose a cycle number with a store. When the running count reaches the chosen value, the block raises an interrupt line. The line stays high until software stores to a second, acknowledge address.

The block recognises its own two addresses and reports a hit, so that the surrounding datapath can keep data memory from seeing the access. Its read-data output drives a shared bus only during a load from the count address. At all other times that output is high impedance, so data memory can drive the same wires.

Top module: `cycle_timer`

## Requirements
- R1: A synchronous reset clears the cycle count, the compare value and the interrupt line to zero.
- R2: While `mem_rd` is 1 and `addr` equals 0xffff001c, `rdata` carries the current cycle count.
- R3: A clock edge with `mem_wr` at 1 and `addr` at 0xffff001c loads `wdata` into the compare register.
- R4: Outside reset, the cycle count rises by exactly one at every clock edge, whatever the bus is doing.
- R5: At any edge where the count equals the compare value, `irq` is 1 after that edge. Because the compare value resets to 0, this happens at the first edge after reset is released.
- R6: Once `irq` is 1, it stays 1 until an acknowledge store or a reset.
- R7: A store of any data to address 0xffff006c clears `irq` at that edge, provided the count does not match the compare value in the same cycle.
- R8: If an acknowledge store and a match happen in the same cycle, `irq` is 1 after the edge.
- R9: When no load from 0xffff001c is taking place, `rdata` is high impedance. This includes loads from the acknowledge address and stores to the count address.
- R10: `addr_hit` is 1 exactly when `addr` equals 0xffff001c or 0xffff006c, independent of `mem_rd` and `mem_wr`.
- R11: Loads and stores to any other address leave the compare value and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 32 | Bus address |
| wdata | input | 32 | Store data |
| mem_rd | input | 1 | Load in progress |
| mem_wr | input | 1 | Store in progress |
| rdata | output | 32 | Cycle count during a timer load, high impedance otherwise |
| addr_hit | output | 1 | Address is one of the two timer addresses |
| irq | output | 1 | Timer interrupt request |

## Verification
There are two main ways an internal fault can show up. A wrong count appears on the very next load from the count address. A wrong compare value or a wrong interrupt flop only appears when `irq` rises a cycle early or late, fails to hold, or fails to clear. The bench therefore times each programmed match to the exact edge, and checks the line on either side of that edge. The bench also models a data memory that drives the shared bus. If the timer fails to release the bus, the memory's data comes back corrupted in the same cycle.

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int          W        = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] CNT_ADDR = 32'hffff_001c,
  parameter logic [31:0] ACK_ADDR = 32'hffff_006c
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          mem_rd,
  input  logic          mem_wr,
  output logic [W-1:0]  rdata,
  output logic          addr_hit,
  output logic          irq
);

  localparam logic [AW-1:0] SEL_CNT = AW'(CNT_ADDR);
  localparam logic [AW-1:0] SEL_ACK = AW'(ACK_ADDR);

  logic [W-1:0] cnt_q, cmp_q;
  logic         irq_q;

  wire on_cnt = (addr == SEL_CNT);
  wire on_ack = (addr == SEL_ACK);
  wire rd_hit = on_cnt & mem_rd;
  wire cmp_we = on_cnt & mem_wr;
  wire ack    = on_ack & mem_wr;
  wire match  = (cnt_q == cmp_q);

  assign addr_hit = on_cnt | on_ack;
  assign rdata    = rd_hit ? cnt_q : 'z;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cmp_we) cmp_q <= wdata;
      irq_q <= match | (irq_q & ~ack);
    end
  end

endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
  parameter int          W        = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] CNT_ADDR = 32'hffff_001c,
  parameter logic [31:0] ACK_ADDR = 32'hffff_006c
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          mem_wr,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  cmp,
  input logic          irq
);

  wire st_cnt = mem_wr && (addr == AW'(CNT_ADDR));
  wire st_ack = mem_wr && (addr == AW'(ACK_ADDR));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && cmp == '0 && !irq));

  a_r3_cmp_load: assert property (@(posedge clk) disable iff (rst)
    st_cnt |=> cmp == $past(wdata));

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != {W{1'b1}}) |=> cnt == $past(cnt) + 1'b1);

  a_r5_match_sets: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp) |=> irq);

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !st_ack) |=> irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (st_ack && cnt != cmp) |=> !irq);

  a_r8_match_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (st_ack && cnt == cmp) |=> irq);

endmodule

bind cycle_timer cycle_timer_chk #(
  .W(W), .AW(AW), .CNT_ADDR(CNT_ADDR), .ACK_ADDR(ACK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .mem_wr(mem_wr),
  .cnt(cnt_q), .cmp(cmp_q), .irq(irq_q)
);

// File: tb/cycle_timer_bench.sv
`timescale 1ns/1ps
module cycle_timer_bench;
  localparam logic [31:0] A_CNT = 32'hffff_001c;
  localparam logic [31:0] A_ACK = 32'hffff_006c;
  localparam logic [31:0] A_OTH = 32'hffff_0020;
  localparam logic [31:0] PAT   = 32'ha5c3_0f96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] addr = '0, wdata = '0;
  logic mem_rd = 1'b0, mem_wr = 1'b0, mem_en = 1'b0;
  logic addr_hit, irq;
  tri [31:0] bus;
  logic [31:0] exp_cnt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign bus = mem_en ? PAT : 'z;

  cycle_timer u_cycle_timer (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rdata(bus), .addr_hit(addr_hit), .irq(irq)
  );

  always @(posedge clk) exp_cnt <= rst ? 32'd0 : exp_cnt + 32'd1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    mem_rd = 1'b0; mem_wr = 1'b0; mem_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    addr = a; wdata = d; mem_wr = 1'b1;
    step();
    idle();
  endtask

  task automatic wait_for(input logic [31:0] c);
    for (int i = 0; i < 2000 && exp_cnt != c; i++) step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    addr = A_CNT; mem_rd = 1'b1;
    #1;
    check(bus === 32'd0, "R1 count zero in reset", bus, 0);
    check(irq === 1'b0, "R1 irq low in reset", {31'd0, irq}, 0);
    idle();
  endtask

  task automatic t_first_match();
    rst = 1'b0;
    step();
    check(irq === 1'b1, "R5 compare reset value matches first count", {31'd0, irq}, 1);
    store(A_ACK, 32'h1234);
    check(irq === 1'b0, "R7 ack clears", {31'd0, irq}, 0);
  endtask

  task automatic t_read();
    logic [31:0] first;
    addr = A_CNT; mem_rd = 1'b1;
    #1;
    first = bus;
    check(bus === exp_cnt, "R2 load returns count", bus, exp_cnt);
    step();
    #1;
    check(bus === first + 32'd1, "R4 count steps by one", bus, first + 32'd1);
    mem_rd = 1'b0; addr = A_CNT; wdata = 32'hffff_ffff; mem_wr = 1'b1;
    step();
    idle();
    addr = A_CNT; mem_rd = 1'b1;
    #1;
    check(bus === first + 32'd2, "R4 count steps during store", bus, first + 32'd2);
    idle();
    store(A_CNT, 32'hffff_ff00);
  endtask

  task automatic t_hit();
    addr = A_CNT; #1;
    check(addr_hit === 1'b1, "R10 hit on count address", {31'd0, addr_hit}, 1);
    addr = A_ACK; #1;
    check(addr_hit === 1'b1, "R10 hit on ack address", {31'd0, addr_hit}, 1);
    addr = A_OTH; mem_rd = 1'b1; #1;
    check(addr_hit === 1'b0, "R10 no hit elsewhere", {31'd0, addr_hit}, 0);
    addr = A_CNT ^ 32'h8000_0000; #1;
    check(addr_hit === 1'b0, "R10 no hit one bit off", {31'd0, addr_hit}, 0);
    idle();
  endtask

  task automatic t_float();
    addr = A_OTH; mem_rd = 1'b1; mem_en = 1'b1; #1;
    check(bus === PAT, "R9 floats on memory load", bus, PAT);
    addr = A_ACK; #1;
    check(bus === PAT, "R9 floats on load from ack address", bus, PAT);
    mem_rd = 1'b0; mem_wr = 1'b1; addr = A_CNT; wdata = 32'hffff_ff00; #1;
    check(bus === PAT, "R9 floats on store to count", bus, PAT);
    idle();
  endtask

  task automatic t_match();
    logic [31:0] c;
    c = exp_cnt + 32'd12;
    store(A_CNT, c);
    wait_for(c);
    check(irq === 1'b0, "R3 R5 no irq before match edge", {31'd0, irq}, 0);
    step();
    check(irq === 1'b1, "R5 irq after match edge", {31'd0, irq}, 1);
    repeat (6) step();
    check(irq === 1'b1, "R6 irq held", {31'd0, irq}, 1);
    store(A_ACK, 32'd0);
    check(irq === 1'b0, "R7 ack with zero data clears", {31'd0, irq}, 0);
    store(A_ACK, 32'd7);
    check(irq === 1'b0, "R7 ack when idle stays low", {31'd0, irq}, 0);
  endtask

  task automatic t_other();
    logic [31:0] c;
    c = exp_cnt + 32'd20;
    store(A_CNT, c);
    store(A_OTH, exp_cnt + 32'd3);
    addr = A_OTH; mem_rd = 1'b1; mem_en = 1'b1;
    step();
    idle();
    check(irq === 1'b0, "R11 other access leaves irq", {31'd0, irq}, 0);
    wait_for(c);
    step();
    check(irq === 1'b1, "R11 compare unchanged by other store", {31'd0, irq}, 1);
    store(A_OTH, 32'd0);
    check(irq === 1'b1, "R11 other store is no ack", {31'd0, irq}, 1);
    store(A_ACK, 32'd0);
  endtask

  task automatic t_ack_match();
    logic [31:0] c;
    c = exp_cnt + 32'd9;
    store(A_CNT, c);
    wait_for(c);
    store(A_ACK, 32'd1);
    check(irq === 1'b1, "R8 match wins over ack", {31'd0, irq}, 1);
    store(A_ACK, 32'd1);
    check(irq === 1'b0, "R8 later ack clears", {31'd0, irq}, 0);
  endtask

  task automatic t_rereset();
    store(A_CNT, exp_cnt + 32'd3);
    repeat (4) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    addr = A_CNT; mem_rd = 1'b1; #1;
    check(bus === 32'd0, "R1 count cleared by reset", bus, 0);
    check(irq === 1'b0, "R1 irq cleared by reset", {31'd0, irq}, 0);
    idle();
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_match();
    t_read();
    t_hit();
    t_float();
    t_match();
    t_other();
    t_ack_match();
    t_rereset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule